// File: doc/BRIEF.md
# Protected Runtime System Clock Prescaler

This block turns a master clock into a system clock enable whose rate software picks at run time. A single 8-bit control register holds the divider code, and a change-enable flag guards it. Software first writes the exact unlock value `0x80`. It then has four clock cycles to write a new divider code. A code written outside that window is dropped. The divider moves to a new rate only when its current period ends, so the enable never produces a runt pulse.

A strap input picks the divider code that reset loads: either divide-by-1 or divide-by-8. A mode input doubles every division factor for the case where an internal RC oscillator is the clock source.

The guard is a two-state machine, `UL_LOCKED` and `UL_ARMED`, with these transitions:
- **arm** (`UL_LOCKED` to `UL_ARMED`): a write of exactly `0x80`.
- **commit** (`UL_ARMED` to `UL_LOCKED`): any other write. It loads the code.
- **expire** (`UL_ARMED` to `UL_LOCKED`): the window counter reaches zero.
- **hold**: every other case. This includes a repeated `0x80` while armed, which only lets the counter run on.

Top module: `sysclk_prescaler`

## Requirements
- R1: The register reads as {bit 7 = change-enable flag, bits 6:4 = 0, bits 3:0 = divider code}. The readback is combinational from the stored state.
- R2: Only a write of exactly `0x80` sets the change-enable flag. A write with any other bit set, such as `0x81`, does not set it.
- R3: After the arming write, the change-enable flag reads 1 for exactly four cycles. It then clears with no further write.
- R4: A write of `0x80` while the flag is set neither restarts the four-cycle window nor clears the flag.
- R5: A write other than `0x80` while the flag is set loads bits 3:0 into the divider code and clears the flag at once. A write other than `0x80` while the flag is clear changes nothing.
- R6: With `rc_mode` = 0, codes 0 to 8 give a clk_en period of 2^code cycles.
- R7: With `rc_mode` = 1, codes 0 to 8 give a period of 2^(code+1) cycles.
- R8: Codes 9 to 15 are stored and read back as written. The divider treats them as code 0, giving period 1, or 2 in RC mode.
- R9: Reset loads code 0 when `strap_div8` = 0 and code 3 when it is 1. After reset, any code can be written whatever the strap value.
- R10: clk_en is high for one cycle per period. A new factor takes effect only in the cycle after a clk_en pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strap_div8 | input | 1 | Selects reset code 3 (divide by 8) when high |
| rc_mode | input | 1 | Doubles every division factor when high |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write value |
| rd_data | output | 8 | Register readback |
| clk_en | output | 1 | One-cycle enable per divided period |

## Verification
The bench uses the default parameters: a four-cycle window, codes up to 8, and a 9-bit period counter. With these values the longest period, 512 cycles in RC mode, fits easily in a run, so every boundary hand-over can be observed. Reset is applied once with the strap low and once with it high. A cycle-level reference model runs alongside the random write traffic. Directed cases measure the window length with and without a repeated unlock, rejected writes, reserved codes and the period for each mode.

// File: rtl/psc_pkg.sv
package psc_pkg;
    typedef enum logic {UL_LOCKED, UL_ARMED} unlock_e;

    localparam logic [7:0] ARM_CODE = 8'h80;

    // shift amount applied by the divider for a stored code
    function automatic int eff_shift(int code, logic rc, int max_code);
        return ((code > max_code) ? 0 : code) + (rc ? 1 : 0);
    endfunction
endpackage

// File: rtl/psc_unlock.sv
module psc_unlock #(
    parameter int WINDOW     = 4,
    parameter int SEL_W      = 4,
    parameter int STRAP_CODE = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             strap_div8,
    input  logic             wr_en,
    input  logic [7:0]       wr_data,
    output logic             armed,
    output logic [SEL_W-1:0] sel
);
    import psc_pkg::*;

    localparam int WIN_W = (WINDOW > 2) ? $clog2(WINDOW) : 1;
    localparam logic [WIN_W-1:0] WIN_LOAD = WIN_W'(WINDOW - 1);

    unlock_e          state_q, state_d;
    logic [WIN_W-1:0] win_q, win_d;
    logic [SEL_W-1:0] sel_q, sel_d;
    logic             arm_wr, sel_wr;

    assign arm_wr = wr_en && (wr_data == ARM_CODE);
    assign sel_wr = wr_en && (wr_data != ARM_CODE);

    always_comb begin
        state_d = state_q;
        win_d   = win_q;
        sel_d   = sel_q;
        unique case (state_q)
            UL_LOCKED: begin
                if (arm_wr) begin
                    state_d = UL_ARMED;
                    win_d   = WIN_LOAD;
                end
            end
            UL_ARMED: begin
                if (sel_wr) begin
                    state_d = UL_LOCKED;
                    sel_d   = wr_data[SEL_W-1:0];
                end else if (win_q == '0) begin
                    state_d = UL_LOCKED;
                end else begin
                    win_d = win_q - 1'b1;
                end
            end
            default: state_d = UL_LOCKED;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= UL_LOCKED;
            win_q   <= '0;
            sel_q   <= strap_div8 ? SEL_W'(STRAP_CODE) : '0;
        end else begin
            state_q <= state_d;
            win_q   <= win_d;
            sel_q   <= sel_d;
        end
    end

    always_comb begin
        armed = (state_q == UL_ARMED);
        sel   = sel_q;
    end

    a_r2_arm_needs_clean_write: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(armed) |-> $past(wr_en && (wr_data == ARM_CODE)));
    a_r3_window_expires: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && win_q == '0 && !sel_wr) |=> !armed);
    a_r4_rearm_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && win_q != '0 && arm_wr) |=> (armed && win_q == $past(win_q) - 1'b1));
    a_r5_locked_code_held: assert property (@(posedge clk) disable iff (!rst_n)
        !armed |=> $stable(sel_q));
    a_r5_commit_disarms: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && sel_wr) |=> (!armed && sel_q == $past(wr_data[SEL_W-1:0])));
endmodule

// File: rtl/psc_divider.sv
module psc_divider #(
    parameter int MAX_CODE   = 8,
    parameter int SEL_W      = 4,
    parameter int STRAP_CODE = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             strap_div8,
    input  logic             rc_mode,
    input  logic [SEL_W-1:0] sel,
    output logic             clk_en
);
    import psc_pkg::*;

    localparam int CNT_W = MAX_CODE + 1;
    localparam int SH_W  = $clog2(MAX_CODE + 2);

    logic [SH_W-1:0]  act_sh_q, req_sh, rst_sh;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W:0]   period, last;

    assign req_sh = SH_W'(eff_shift(int'(sel), rc_mode, MAX_CODE));
    assign rst_sh = SH_W'(eff_shift(strap_div8 ? STRAP_CODE : 0, rc_mode, MAX_CODE));
    assign period = (CNT_W + 1)'(1) << act_sh_q;
    assign last   = period - 1'b1;
    assign clk_en = ({1'b0, cnt_q} == last);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            act_sh_q <= rst_sh;
            cnt_q    <= '0;
        end else if (clk_en) begin
            act_sh_q <= req_sh;
            cnt_q    <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    a_r10_rate_held_mid_period: assert property (@(posedge clk) disable iff (!rst_n)
        !clk_en |=> $stable(act_sh_q));
    a_r10_count_in_period: assert property (@(posedge clk) disable iff (!rst_n)
        ({1'b0, cnt_q} < period));
endmodule

// File: rtl/sysclk_prescaler.sv
module sysclk_prescaler #(
    parameter int WINDOW     = 4,
    parameter int MAX_CODE   = 8,
    parameter int STRAP_CODE = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       strap_div8,
    input  logic       rc_mode,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    output logic [7:0] rd_data,
    output logic       clk_en
);
    localparam int SEL_W = 4;

    logic             armed;
    logic [SEL_W-1:0] sel;

    psc_unlock #(.WINDOW(WINDOW), .SEL_W(SEL_W), .STRAP_CODE(STRAP_CODE)) u_unlock (
        .clk(clk), .rst_n(rst_n), .strap_div8(strap_div8),
        .wr_en(wr_en), .wr_data(wr_data), .armed(armed), .sel(sel)
    );

    psc_divider #(.MAX_CODE(MAX_CODE), .SEL_W(SEL_W), .STRAP_CODE(STRAP_CODE)) u_div (
        .clk(clk), .rst_n(rst_n), .strap_div8(strap_div8),
        .rc_mode(rc_mode), .sel(sel), .clk_en(clk_en)
    );

    assign rd_data = {armed, 3'b000, sel};

    a_r1_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[6:4] == 3'b000);
endmodule

// File: tb/tb_sysclk_prescaler.sv
module tb_sysclk_prescaler;
    logic       clk = 0;
    logic       rst_n = 0;
    logic       strap_div8 = 0;
    logic       rc_mode = 0;
    logic       wr_en = 0;
    logic [7:0] wr_data = 0;
    logic [7:0] rd_data;
    logic       clk_en;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    sysclk_prescaler dut (.*);

    always #2 clk = ~clk;

    // reference model of the requirements
    bit       m_arm;
    int       m_win;
    int       m_sel;
    int       m_sh;
    int       m_cnt;

    function automatic int shift_of(int code, bit rc);
        return ((code > 8) ? 0 : code) + (rc ? 1 : 0);
    endfunction

    function automatic bit exp_en();
        return m_cnt == ((1 << m_sh) - 1);
    endfunction

    function automatic int exp_rd();
        return (m_arm ? 128 : 0) + m_sel;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_arm <= 0; m_win <= 0;
            m_sel <= strap_div8 ? 3 : 0;
            m_sh  <= shift_of(strap_div8 ? 3 : 0, rc_mode);
            m_cnt <= 0;
        end else begin
            if (wr_en && wr_data == 8'h80 && !m_arm) begin
                m_arm <= 1; m_win <= 3;
            end else if (wr_en && wr_data != 8'h80 && m_arm) begin
                m_arm <= 0; m_sel <= int'(wr_data[3:0]);
            end else if (m_arm) begin
                if (m_win == 0) m_arm <= 0;
                else m_win <= m_win - 1;
            end
            if (exp_en()) begin
                m_cnt <= 0; m_sh <= shift_of(m_sel, rc_mode);
            end else m_cnt <= m_cnt + 1;
        end
    end

    task automatic check(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // every-cycle comparison against the model (R1, R10 and the rest)
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check(rd_data == 8'(exp_rd()), "R1 model readback", rd_data, exp_rd());
            check(clk_en == exp_en(), "R10 model clk_en", clk_en, exp_en());
        end
    end

    // caller is at a negedge
    task automatic wr(input logic [7:0] d);
        wr_en = 1; wr_data = d;
        @(negedge clk);
        wr_en = 0; wr_data = 0;
    endtask

    task automatic measure(output int gap);
        int guard = 0;
        gap = 0;
        while (!clk_en && guard < 2000) begin @(negedge clk); guard++; end
        @(negedge clk); gap = 1;
        while (!clk_en && gap < 2000) begin @(negedge clk); gap++; end
    endtask

    task automatic set_code(input logic [7:0] c);
        int g;
        wr(8'h80); wr(c);
        measure(g); measure(g);
    endtask

    task automatic do_reset(input bit strap);
        @(negedge clk);
        rst_n = 0; strap_div8 = strap;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
    endtask

    initial begin
        int gap;
        do_reset(0);
        check(rd_data == 8'h00, "R9 reset strap low", rd_data, 8'h00);
        check(clk_en == 1'b1, "R6 code0 enable every cycle", clk_en, 1);

        // R2: unclean write does not arm
        wr(8'h81);
        check(rd_data[7] == 1'b0, "R2 0x81 not arming", rd_data[7], 0);
        // R5: locked write ignored
        wr(8'h05);
        check(rd_data == 8'h00, "R5 locked write ignored", rd_data, 0);

        // R3: window of four cycles
        wr(8'h80);
        check(rd_data == 8'h80, "R2 armed readback", rd_data, 8'h80);
        repeat (3) begin
            @(negedge clk);
            check(rd_data[7] == 1'b1, "R3 flag in window", rd_data[7], 1);
        end
        @(negedge clk);
        check(rd_data[7] == 1'b0, "R3 flag expired", rd_data[7], 0);

        // R4: rewrite does not extend
        wr(8'h80); wr(8'h80);
        check(rd_data[7] == 1'b1, "R4 rewrite keeps flag", rd_data[7], 1);
        @(negedge clk);
        check(rd_data[7] == 1'b1, "R4 still armed", rd_data[7], 1);
        @(negedge clk);
        check(rd_data[7] == 1'b1, "R4 last window cycle", rd_data[7], 1);
        @(negedge clk);
        check(rd_data[7] == 1'b0, "R4 window not extended", rd_data[7], 0);

        // R5 commit and R1 reserved bits
        wr(8'h80); wr(8'h75);
        check(rd_data == 8'h05, "R1 R5 commit clears flag", rd_data, 8'h05);

        set_code(8'h03);
        measure(gap);
        check(gap == 8, "R6 period code3", gap, 8);
        rc_mode = 1;
        measure(gap); measure(gap);
        check(gap == 16, "R7 period code3 rc", gap, 16);
        set_code(8'h08);
        measure(gap);
        check(gap == 512, "R7 period code8 rc", gap, 512);
        rc_mode = 0;
        measure(gap); measure(gap);
        check(gap == 256, "R6 period code8", gap, 256);

        set_code(8'h0C);
        check(rd_data == 8'h0C, "R8 reserved stored", rd_data, 8'h0C);
        measure(gap);
        check(gap == 1, "R8 reserved as factor 1", gap, 1);

        do_reset(1);
        check(rd_data == 8'h03, "R9 reset strap high", rd_data, 8'h03);
        measure(gap); measure(gap);
        check(gap == 8, "R9 strap divide by 8", gap, 8);
        set_code(8'h01);
        measure(gap);
        check(gap == 2, "R9 any code under strap", gap, 2);

        // random traffic checked by the model
        void'($urandom(32'h5eed_1234));
        for (int i = 0; i < 6000; i++) begin
            int r = $urandom_range(0, 9);
            if (r < 3) wr(8'h80);
            else if (r < 5) wr(8'($urandom_range(0, 5)) | ($urandom_range(0, 3) == 0 ? 8'h0C : 8'h00));
            else if (r == 5) wr(8'($urandom));
            else begin
                if ($urandom_range(0, 60) == 0) rc_mode = ~rc_mode;
                @(negedge clk);
            end
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(4 * 150000);
        if (!done) begin
            done = 1;
            errors++; checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule